// File: doc/BRIEF.md
# Byte Read/Write Adapter for a Word-Only Memory

This block lets a requester that works in single bytes use a memory that can only be read and written as whole 128-bit words and has no byte enables. The requester presents one byte address, a direction and, for a store, one data byte, using a valid/ready handshake. The adapter drops the four lowest address bits before the memory sees the address. It uses them only to pick a byte lane inside the fetched word.

A byte load issues one word read. The adapter waits for the memory's read-valid strobe, so any read latency works. It then returns the chosen lane at the bottom of a wider result bus with every other bit cleared. A byte store is a read-modify-write: the adapter fetches the aligned word, overwrites one lane, and writes all sixteen bytes back to the same word address. Only one transaction is in flight at a time. Each one ends with a single-cycle response strobe.

Top module: `byte_rmw_adapter`

## Requirements
- R1: During and directly after reset the adapter is idle: `reqReady` is 1, and `memReq` and `rspValid` are 0.
- R2: Every memory access uses word address `memAddr = reqAddr >> 4`. Byte-address bits [3:0] never reach the memory.
- R3: A load (`reqWrite`=0) makes exactly one memory read and no memory write. When `rspValid` is high, `rspRdata[7:0]` holds byte lane `reqAddr[3:0]` of the fetched word, where lane k is word bits [8k+7:8k], and `rspRdata[63:8]` is zero.
- R4: A store (`reqWrite`=1) makes exactly one memory read followed by exactly one memory write, both to the same word address. The written word equals the fetched word with lane `reqAddr[3:0]` replaced by `reqWdata`, and the other 15 lanes unchanged.
- R5: A request is accepted only on a cycle where `reqReady` is 1. `reqReady` stays 0 from the acceptance edge until the cycle after the response. A request held during that time starts no memory access.
- R6: Let the read be issued in cycle c, with `memRvalid` in cycle c+L. A load asserts `rspValid` in cycle c+L+1. A store issues its write in cycle c+L+2 and asserts `rspValid` in cycle c+L+3. `rspValid` lasts one cycle.
- R7: `memRvalid` while the adapter is not waiting for read data is ignored. No response is produced, no memory access starts, and `reqReady` stays 1.
- R8: `memReq` is a one-cycle pulse per memory access, and `memWe` is 1 only on the write pulse of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester presents a byte access |
| reqReady | output | 1 | Adapter can accept a request |
| reqWrite | input | 1 | 1 = byte store, 0 = byte load |
| reqAddr | input | ADDR_W (32) | Byte address |
| reqWdata | input | 8 | Byte to store |
| rspValid | output | 1 | One-cycle completion strobe |
| rspRdata | output | DATA_W (64) | Loaded byte in [7:0], upper bits zero |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Access is a word write |
| memAddr | output | ADDR_W-4 (28) | Word address |
| memWdata | output | 128 | Word to write |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 128 | Read word |

## Verification
The risky internal state is the lane select and the captured word. A wrong lane shows up on `rspRdata` in the response cycle of the first load that hits it. A merge into the wrong lane is visible on `memWdata` during the write pulse, and again on a later load of a neighbouring byte. A sequencer stuck in the wrong state appears at once as a response cycle shifted away from the L+1 or L+3 count, or as an extra or missing `memReq` pulse. The bench varies the memory latency per transaction to expose code that counts cycles instead of waiting for `memRvalid`.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_MODIFY,
    ST_WRITE_REQ,
    ST_DONE
  } adapt_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureReq;   // latch address, lane and store byte
    logic captureWord;  // latch the word returned by memory
    logic mergeByte;    // overwrite the selected lane
  } dp_strobe_t;

endpackage

// File: rtl/byte_rmw_ctrl.sv
module byte_rmw_ctrl
  import byte_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  input  logic       memRvalid,
  output logic       memReq,
  output logic       memWe,
  output logic       rspValid,
  output dp_strobe_t strobe
);

  adapt_state_e state, stateNext;
  logic         isWrite;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.captureReq = reqValid;
        if (reqValid) stateNext = ST_READ_REQ;
      end
      ST_READ_REQ:  stateNext = ST_READ_WAIT;
      ST_READ_WAIT: begin
        strobe.captureWord = memRvalid;
        if (memRvalid) stateNext = isWrite ? ST_MODIFY : ST_DONE;
      end
      ST_MODIFY: begin
        strobe.mergeByte = 1'b1;
        stateNext        = ST_WRITE_REQ;
      end
      ST_WRITE_REQ: stateNext = ST_DONE;
      ST_DONE:      stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.captureReq) isWrite <= reqWrite;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_READ_REQ) || (state == ST_WRITE_REQ);
  assign memWe    = (state == ST_WRITE_REQ);
  assign rspValid = (state == ST_DONE);

  // R8: each memory access is a single-cycle pulse
  p_memreq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R6: response lasts one cycle and the adapter is idle right after
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R5: no memory traffic while the requester side is open
  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  // R4: a word write always follows the lane merge
  p_write_after_merge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> $past(strobe.mergeByte));

  // R7: read data outside the wait state leaves the idle adapter idle
  p_stray_rvalid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid && memRvalid) |=> reqReady);

endmodule

// File: rtl/byte_rmw_datapath.sv
module byte_rmw_datapath
  import byte_rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 16,
  parameter int DATA_W     = 64,
  localparam int LANE_W    = $clog2(WORD_BYTES),
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WADDR_W   = ADDR_W - LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          reqWdata,
  input  logic [WORD_W-1:0]   memRdata,
  output logic [WADDR_W-1:0]  memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   rspRdata
);

  logic [WADDR_W-1:0] wordAddrReg;
  logic [LANE_W-1:0]  laneReg;
  logic [7:0]         wdataReg;
  logic [WORD_W-1:0]  wordReg;
  logic [7:0]         laneByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddrReg <= '0;
      laneReg     <= '0;
      wdataReg    <= '0;
    end else if (strobe.captureReq) begin
      wordAddrReg <= reqAddr[ADDR_W-1:LANE_W];
      laneReg     <= reqAddr[LANE_W-1:0];
      wdataReg    <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobe.captureWord) begin
      wordReg <= memRdata;
    end else if (strobe.mergeByte) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (laneReg == LANE_W'(i)) wordReg[i*8 +: 8] <= wdataReg;
      end
    end
  end

  always_comb begin
    laneByte = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (laneReg == LANE_W'(i)) laneByte = wordReg[i*8 +: 8];
    end
  end

  assign memAddr  = wordAddrReg;
  assign memWdata = wordReg;
  assign rspRdata = {{(DATA_W-8){1'b0}}, laneByte};

  // R4: per lane, the merge touches only the addressed lane
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_laneChk
    p_lane_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.mergeByte && laneReg != LANE_W'(g)) |=> $stable(wordReg[g*8 +: 8]));
    p_lane_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.mergeByte && laneReg == LANE_W'(g)) |=> (wordReg[g*8 +: 8] == $past(wdataReg)));
  end

  // R2: the word address holds steady for the whole transaction
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureWord || strobe.mergeByte) |=> $stable(memAddr));

endmodule

// File: rtl/byte_rmw_adapter.sv
module byte_rmw_adapter
  import byte_rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 16,
  parameter int DATA_W     = 64,
  localparam int LANE_W    = $clog2(WORD_BYTES),
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WADDR_W   = ADDR_W - LANE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspRdata,
  output logic               memReq,
  output logic               memWe,
  output logic [WADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic               memRvalid,
  input  logic [WORD_W-1:0]  memRdata
);

  dp_strobe_t strobe;

  byte_rmw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .memRvalid (memRvalid),
    .memReq    (memReq),
    .memWe     (memWe),
    .rspValid  (rspValid),
    .strobe    (strobe)
  );

  byte_rmw_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rspRdata (rspRdata)
  );

  // R1: reset leaves the adapter idle with the memory side quiet
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (reqReady && !memReq && !rspValid));

endmodule

// File: tb/byte_rmw_adapter_tb.sv
module byte_rmw_adapter_tb;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 64;
  localparam int WORD_W  = 128;
  localparam int WADDR_W = 28;

  // {store, latency[3:0], byte[7:0], address[31:0]}
  localparam logic [44:0] VEC [10] = '{
    {1'b0, 4'd1, 8'h00, 32'h0000_0012},
    {1'b1, 4'd1, 8'hC3, 32'h0000_0013},
    {1'b0, 4'd2, 8'h00, 32'h0000_0013},
    {1'b0, 4'd3, 8'h00, 32'h0000_0012},
    {1'b1, 4'd5, 8'h7E, 32'hABCD_0020},
    {1'b0, 4'd1, 8'h00, 32'hABCD_0020},
    {1'b1, 4'd2, 8'hFF, 32'h0000_007F},
    {1'b0, 4'd4, 8'h00, 32'h0000_007F},
    {1'b0, 4'd1, 8'h00, 32'h0000_007E},
    {1'b1, 4'd3, 8'h01, 32'hFFFF_FFF0}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic               reqWrite = 1'b0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic [7:0]         reqWdata = '0;
  logic               rspValid;
  logic [DATA_W-1:0]  rspRdata;
  logic               memReq;
  logic               memWe;
  logic [WADDR_W-1:0] memAddr;
  logic [WORD_W-1:0]  memWdata;
  logic               memRvalid;
  logic [WORD_W-1:0]  memRdata;

  always #4 clk = ~clk;

  byte_rmw_adapter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRvalid(memRvalid),
    .memRdata(memRdata)
  );

  // memory model: 8 words, aliased on word address bits [2:0]
  logic [WORD_W-1:0]  mem [8];
  logic [WORD_W-1:0]  shadow [8];
  logic [WORD_W-1:0]  pendData = '0;
  logic [WORD_W-1:0]  wrWord = '0;
  logic [WADDR_W-1:0] rdAddr = '0, wrAddr = '0;
  int  pendCnt = 0, curLat = 1, cyc = 0;
  int  rdCount = 0, wrCount = 0, rdStamp = 0, wrStamp = 0;
  bit  strayRv = 1'b0;
  int  checks = 0, fails = 0;

  assign memRvalid = (pendCnt == 1) || strayRv;
  assign memRdata  = pendData;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq && !memWe) begin
      pendCnt  <= curLat;
      pendData <= mem[memAddr[2:0]];
      rdCount  <= rdCount + 1;
      rdAddr   <= memAddr;
      rdStamp  <= cyc;
    end else if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
    end
    if (memReq && memWe) begin
      mem[memAddr[2:0]] <= memWdata;
      wrCount <= wrCount + 1;
      wrAddr  <= memAddr;
      wrWord  <= memWdata;
      wrStamp <= cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runTxn(input bit wr, input logic [31:0] addr, input logic [7:0] wd,
                        input int lat, input bit holdBusy);
    int n, rd0, wr0, readyBusy;
    logic [2:0] idx;
    logic [3:0] lane;
    logic [WORD_W-1:0] expWord;
    idx  = addr[6:4];
    lane = addr[3:0];
    curLat = lat;
    @(negedge clk);
    chk(reqReady == 1'b1, "R5", "ready before request", WORD_W'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    rd0 = rdCount; wr0 = wrCount;
    @(negedge clk);
    if (holdBusy) begin
      reqAddr = addr ^ 32'h0000_0050; reqWrite = ~wr;
    end else begin
      reqValid = 1'b0;
    end
    n = 1; readyBusy = 0;
    while (!rspValid && n < 64) begin
      if (reqReady) readyBusy++;
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    chk(readyBusy == 0, "R5", "ready while busy", WORD_W'(readyBusy), 0);
    chk(n == (wr ? lat + 4 : lat + 2), "R6", "response cycle", WORD_W'(n),
        WORD_W'(wr ? lat + 4 : lat + 2));
    chk(rdCount - rd0 == 1, wr ? "R4" : "R3", "read count", WORD_W'(rdCount - rd0), 1);
    chk(rdAddr == addr[31:4], "R2", "read word address", WORD_W'(rdAddr), WORD_W'(addr[31:4]));
    if (wr) begin
      expWord = shadow[idx];
      expWord[lane*8 +: 8] = wd;
      chk(wrCount - wr0 == 1, "R4", "write count", WORD_W'(wrCount - wr0), 1);
      chk(wrAddr == addr[31:4], "R2", "write word address", WORD_W'(wrAddr), WORD_W'(addr[31:4]));
      chk(wrWord == expWord, "R4", "written word", wrWord, expWord);
      chk(wrStamp - rdStamp == lat + 2, "R6", "write issue cycle",
          WORD_W'(wrStamp - rdStamp), WORD_W'(lat + 2));
      shadow[idx] = expWord;
    end else begin
      chk(wrCount == wr0, "R3", "no write on load", WORD_W'(wrCount - wr0), 0);
      chk(rspRdata == {56'b0, shadow[idx][lane*8 +: 8]}, "R3", "load data",
          WORD_W'(rspRdata), WORD_W'({56'b0, shadow[idx][lane*8 +: 8]}));
    end
    @(negedge clk);
    chk(rspValid == 1'b0 && reqReady == 1'b1, "R6", "single-cycle response",
        WORD_W'({rspValid, reqReady}), WORD_W'(2'b01));
  endtask

  initial begin
    for (int w = 0; w < 8; w++) begin
      for (int l = 0; l < 16; l++) begin
        mem[w][l*8 +: 8]    = 8'(w * 16 + l) ^ 8'h5A;
        shadow[w][l*8 +: 8] = 8'(w * 16 + l) ^ 8'h5A;
      end
    end
    repeat (3) @(negedge clk);
    chk(reqReady && !memReq && !rspValid, "R1", "state in reset",
        WORD_W'({reqReady, memReq, rspValid}), WORD_W'(3'b100));
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReq && !rspValid, "R1", "state after reset",
        WORD_W'({reqReady, memReq, rspValid}), WORD_W'(3'b100));

    for (int v = 0; v < 10; v++) begin
      runTxn(VEC[v][44], VEC[v][31:0], VEC[v][39:32], int'(VEC[v][43:40]), 1'b0);
    end

    // R5: request held high through a busy store starts nothing extra
    runTxn(1'b1, 32'h0000_0035, 8'h99, 2, 1'b1);
    runTxn(1'b0, 32'h0000_0035, 8'h00, 1, 1'b0);

    // R7: stray read-valid while idle
    begin
      int rd0, wr0, bad;
      rd0 = rdCount; wr0 = wrCount; bad = 0;
      @(negedge clk);
      strayRv = 1'b1;
      @(negedge clk);
      strayRv = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (!reqReady || rspValid || memReq) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R7", "idle outputs after stray rvalid", WORD_W'(bad), 0);
      chk(rdCount == rd0 && wrCount == wr0, "R8", "no access from stray rvalid",
          WORD_W'(rdCount - rd0 + wrCount - wr0), 0);
    end
    runTxn(1'b0, 32'h0000_0036, 8'h00, 6, 1'b0);

    // R8: one read pulse and one write pulse per store
    begin
      int rd0, wr0;
      rd0 = rdCount; wr0 = wrCount;
      runTxn(1'b1, 32'h0000_004F, 8'h3C, 1, 1'b0);
      chk(rdCount - rd0 == 1 && wrCount - wr0 == 1, "R8", "pulses per store",
          WORD_W'({rdCount - rd0, wrCount - wr0}), WORD_W'({32'd1, 32'd1}));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule